// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes one IEEE-754 operand, either single or double precision, and turns it into a single unpacked form that arithmetic units further down the pipeline can share. The unpacked form has five parts: a signed class code, a sign bit, a signed exponent with the bias already removed, a wide mantissa and a sticky flag. The mantissa is 115 bits wide. It carries an explicit leading one at the top bit, a 112-bit fraction field below it, and two low bits kept for guard and round.

Any finite nonzero input comes out normalized with its value in [1.0, 2.0). Subnormal inputs are shifted up inside the same cycle. A leading-zero count taken over the fraction field sets the shift amount, and the exponent is lowered by the same amount. Zero, infinity and the two kinds of NaN appear only in the class code, so consumers never have to test for a denormal or a zero mantissa.

An operand is presented together with a valid strobe. The unpacked result is registered and appears one clock later with its own valid flag. Between results the outputs hold their last value.

Top module: `fp_unpacker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0, and class, sign, exponent, mantissa and sticky are all zero.
- R2: An operand presented with in_valid high in one clock cycle gives out_valid high and the matching result in the next cycle. A cycle with in_valid low gives out_valid low in the next cycle, and every result output keeps its previous value.
- R3: The class output is a 3-bit two's-complement code: -2 for a signalling NaN, -1 for a quiet NaN, 0 for zero, 1 for a finite nonzero number and 2 for infinity. An operand with a zero exponent field and a zero fraction is class 0, with exponent 0 and mantissa 0.
- R4: For a normal operand (exponent field neither all zeros nor all ones), the mantissa has bit 114 set. The stored fraction is left-aligned in bits 113 down to 2, and every bit below it is zero. The exponent is the stored exponent minus 127 for single and minus 1023 for double.
- R5: For a subnormal operand (exponent field zero, fraction nonzero), the mantissa has bit 114 set and the fraction's highest set bit moved to that position, with zeros filled in below. The exponent is (1 - bias) minus the number of places shifted, measured from the top fraction position, so the smallest single subnormal gives -149 and the smallest double subnormal gives -1074.
- R6: An operand with an all-ones exponent field and a zero fraction is class 2, with mantissa 0 and exponent 0.
- R7: An operand with an all-ones exponent field and a nonzero fraction is a NaN. It is quiet (class -1) when the top stored fraction bit is 1 and signalling (class -2) otherwise. Its fraction is left-aligned into bits 113 down to 2, bit 114 is 0 and the exponent is 0.
- R8: The sign output equals the operand's sign bit (bit 31 for single, bit 63 for double) for every class, 1 meaning negative.
- R9: The sticky output is always 0.
- R10: With fmt_dbl = 0 (single), operand bits 63 to 32 have no effect on any output. With fmt_dbl = 1 (double), all 64 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single in bits 31..0 |
| opnd | input | 64 | Packed operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| cls | output | 3 | Signed class code |
| sgn | output | 1 | Sign, 1 = negative |
| expo | output | 16 | Signed unbiased exponent |
| mant | output | 115 | Unpacked mantissa with leading one at bit 114 |
| sticky | output | 1 | Sticky flag, always 0 after unpack |

## Verification
The bench builds the block with its default parameters: a 115-bit mantissa with two guard bits and a 16-bit exponent. At that exponent width the smallest double subnormal, with its exponent of -1074, fits without wrap. The stimulus covers both formats at the extremes of the shift range: a fraction of one gives the longest shift, and a full subnormal fraction gives a one-place shift. It also covers the smallest normal number, signed zeros, infinities and NaNs of both kinds. A single-precision operand with junk in its upper half exposes any leakage from the unused bits.

// File: rtl/fp_unpacker.sv
module fp_unpacker #(
  parameter int MANT_W = 115,
  parameter int GRD_W  = 2,
  parameter int EXP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    fmt_dbl,
  input  logic [63:0]             opnd,
  output logic                    out_valid,
  output logic signed [2:0]       cls,
  output logic                    sgn,
  output logic signed [EXP_W-1:0] expo,
  output logic [MANT_W-1:0]       mant,
  output logic                    sticky
);
  localparam int FRAC_W = MANT_W - 1 - GRD_W;
  localparam int LZW    = $clog2(FRAC_W + 1);
  localparam logic signed [2:0] C_SNAN = -3'sd2;
  localparam logic signed [2:0] C_QNAN = -3'sd1;
  localparam logic signed [2:0] C_ZERO = 3'sd0;
  localparam logic signed [2:0] C_NUM  = 3'sd1;
  localparam logic signed [2:0] C_INF  = 3'sd2;

  logic [10:0]             bexp;
  logic [FRAC_W-1:0]       fld;
  logic                    e_max, e_min, f_nz;
  logic [LZW-1:0]          lz;
  logic [LZW:0]            shamt;
  logic signed [EXP_W-1:0] bias;
  logic signed [2:0]       cls_c;
  logic signed [EXP_W-1:0] exp_c;
  logic [MANT_W-1:0]       mant_c;

  assign bexp  = fmt_dbl ? opnd[62:52] : {3'b000, opnd[30:23]};
  assign e_max = fmt_dbl ? (&opnd[62:52]) : (&opnd[30:23]);
  assign e_min = (bexp == 11'd0);
  assign fld   = fmt_dbl ? {opnd[51:0], {(FRAC_W-52){1'b0}}}
                         : {opnd[22:0], {(FRAC_W-23){1'b0}}};
  assign f_nz  = |fld;
  assign bias  = fmt_dbl ? EXP_W'(1023) : EXP_W'(127);

  always_comb begin
    lz = LZW'(FRAC_W);
    for (int i = 0; i < FRAC_W; i++)
      if (fld[i]) lz = LZW'(FRAC_W - 1 - i);
  end

  assign shamt = (LZW+1)'(lz) + (LZW+1)'(1);

  always_comb begin
    cls_c  = C_ZERO;
    exp_c  = '0;
    mant_c = '0;
    if (e_max) begin
      if (f_nz) begin
        cls_c  = fld[FRAC_W-1] ? C_QNAN : C_SNAN;
        mant_c = {1'b0, fld, {GRD_W{1'b0}}};
      end else begin
        cls_c  = C_INF;
      end
    end else if (e_min) begin
      if (f_nz) begin
        cls_c  = C_NUM;
        mant_c = {1'b0, fld, {GRD_W{1'b0}}} << shamt;
        exp_c  = EXP_W'(1) - bias - EXP_W'(shamt);
      end
    end else begin
      cls_c  = C_NUM;
      mant_c = {1'b1, fld, {GRD_W{1'b0}}};
      exp_c  = EXP_W'(bexp) - bias;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cls       <= C_ZERO;
      sgn       <= 1'b0;
      expo      <= '0;
      mant      <= '0;
      sticky    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cls    <= cls_c;
        sgn    <= fmt_dbl ? opnd[63] : opnd[31];
        expo   <= exp_c;
        mant   <= mant_c;
        sticky <= 1'b0;
      end
    end
  end

  // R4
  num_lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls == C_NUM) |-> mant[MANT_W-1]);
  // R4
  guard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mant[GRD_W-1:0] == '0);
  // R9
  sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky);
  // R7
  qnan_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls == C_QNAN) |-> (mant[MANT_W-2] && !mant[MANT_W-1]));
  // R7
  snan_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls == C_SNAN) |-> (!mant[MANT_W-2] && !mant[MANT_W-1] && mant != '0));
  // R6
  special_mant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (cls == C_ZERO || cls == C_INF)) |-> (mant == '0 && expo == '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(cls) && $stable(mant) && $stable(expo) && $stable(sgn)));
endmodule

// File: tb/fp_unpacker_test.sv
module fp_unpacker_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic signed [2:0]  cls;
    logic               sgn;
    logic signed [15:0] expo;
    logic [114:0]       mant;
    logic [7:0]         req;
  } item_t;

  logic clk = 0, rst_n = 0, in_valid = 0, fmt_dbl = 0;
  logic [63:0] opnd = '0;
  logic out_valid, sgn, sticky;
  logic signed [2:0] cls;
  logic signed [15:0] expo;
  logic [114:0] mant;

  item_t sb[$];
  item_t last;
  int checks = 0, fails = 0;
  bit done = 0;

  fp_unpacker uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
                   .opnd(opnd), .out_valid(out_valid), .cls(cls), .sgn(sgn),
                   .expo(expo), .mant(mant), .sticky(sticky));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic item_t model(input logic dbl, input logic [63:0] w, input logic [7:0] rq);
    item_t r;
    int fw, bias, emax, e, msb;
    logic [51:0] fr;
    fw = dbl ? 52 : 23; bias = dbl ? 1023 : 127; emax = dbl ? 2047 : 255;
    if (dbl) begin r.sgn = w[63]; e = int'(w[62:52]); fr = w[51:0]; end
    else     begin r.sgn = w[31]; e = int'(w[30:23]); fr = {29'b0, w[22:0]}; end
    r.cls = 3'sd0; r.expo = '0; r.mant = '0; r.req = rq;
    if (e == emax) begin
      if (fr != 0) begin
        r.cls  = fr[fw-1] ? -3'sd1 : -3'sd2;
        r.mant = 115'(fr) << (114 - fw);
      end else r.cls = 3'sd2;
    end else if (e == 0) begin
      if (fr != 0) begin
        msb = 0;
        for (int i = 0; i < 52; i++) if (fr[i]) msb = i;
        r.cls  = 3'sd1;
        r.expo = 16'(1 - bias - (fw - msb));
        r.mant = 115'(fr) << (114 - msb);
      end
    end else begin
      r.cls  = 3'sd1;
      r.expo = 16'(e - bias);
      r.mant = (115'(1) << 114) | (115'(fr) << (114 - fw));
    end
    return r;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic drive(input logic dbl, input logic [63:0] w, input logic [7:0] rq);
    @(negedge clk);
    in_valid = 1; fmt_dbl = dbl; opnd = w;
    sb.push_back(model(dbl, w, rq));
    last = model(dbl, w, rq);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; opnd = 64'hA5A5_5A5A_F0F0_0F0F;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      item_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        if (cls !== e.cls || sgn !== e.sgn || expo !== e.expo || mant !== e.mant || sticky !== 1'b0) begin
          fails++;
          $display("FAIL R%0d: actual cls=%0d sgn=%0b exp=%0d mant=%h sticky=%0b expected cls=%0d sgn=%0b exp=%0d mant=%h sticky=0",
                   e.req, cls, sgn, expo, mant, sticky, e.cls, e.sgn, e.expo, e.mant);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++; // R1 reset state
    if (out_valid !== 0 || cls !== 0 || sgn !== 0 || expo !== 0 || mant !== 0 || sticky !== 0) begin
      fails++;
      $display("FAIL R1: actual v=%0b cls=%0d exp=%0d mant=%h expected all zero", out_valid, cls, expo, mant);
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    checks++; // R1 first cycle after reset
    if (out_valid !== 0 || mant !== 0) begin
      fails++;
      $display("FAIL R1: actual v=%0b mant=%h expected 0 0", out_valid, mant);
    end
    // R4 normals, R8 sign
    drive(0, 64'h0000_0000_3F80_0000, 4);
    drive(0, 64'h0000_0000_C020_0000, 8);
    drive(1, 64'h3FF0_0000_0000_0000, 4);
    drive(1, 64'h0010_0000_0000_0000, 4);
    drive(1, 64'hC00C_0000_0000_0001, 8);
    // R3 zeros
    drive(0, 64'h0000_0000_0000_0000, 3);
    drive(0, 64'h0000_0000_8000_0000, 3);
    drive(1, 64'h8000_0000_0000_0000, 3);
    // R5 subnormals
    drive(0, 64'h0000_0000_0000_0001, 5);
    drive(0, 64'h0000_0000_007F_FFFF, 5);
    drive(0, 64'h0000_0000_8040_0000, 5);
    drive(1, 64'h0000_0000_0000_0001, 5);
    drive(1, 64'h800F_FFFF_FFFF_FFFF, 5);
    // R6 infinities
    drive(0, 64'h0000_0000_7F80_0000, 6);
    drive(1, 64'hFFF0_0000_0000_0000, 6);
    // R7 NaNs
    drive(0, 64'h0000_0000_7FC0_0000, 7);
    drive(0, 64'h0000_0000_FF80_0001, 7);
    drive(1, 64'hFFF8_0000_0000_0000, 7);
    drive(1, 64'h7FF0_0000_0000_0001, 7);
    // R10 upper half junk in single mode
    drive(0, 64'hDEAD_BEEF_3F80_0000, 10);
    drive(0, 64'hFFFF_FFFF_0000_0001, 10);
    // R9 sticky checked on every compare
    drive(0, 64'h0000_0000_4049_0FDB, 9);
    // R2 hold while idle
    idle();
    idle();
    @(posedge clk); #2;
    checks++;
    if (out_valid !== 0 || cls !== last.cls || expo !== last.expo || mant !== last.mant || sgn !== last.sgn) begin
      fails++;
      $display("FAIL R2: actual v=%0b cls=%0d mant=%h expected v=0 cls=%0d mant=%h",
               out_valid, cls, mant, last.cls, last.mant);
    end
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: actual %0d pending expected 0", sb.size());
    end
    summary();
  end
endmodule